// File: doc/BRIEF.md
# Indexed Error Record Window

This block holds a bank of error records, each with one 64-bit status register, and exposes them through a narrow register window instead of a flat address range. Software first writes a record number into a 64-bit select register. From then on, every read or write of the window status register lands on the status register of that record. A read-only identification register tells software how many records exist, so it can walk them in a loop.

The register port is a single request channel with a valid strobe, a write flag, a 2-bit address, 64-bit write data and 64-bit read data. Every request gets exactly one response on the following cycle. The response carries the read data and an undefined-access flag. Build-time parameters set the following:

- the record count;
- whether the feature exists at all;
- how the select register behaves when the record count is zero.

Top module: `err_window`

## Requirements
- R1: After reset the select index is 0 and every record status register is 0, so window reads return 0 for every record.
- R2: The select register (address 2'b01) keeps write data bits [15:0] as the index. Its bits [63:16] always read as zero, and write data in those bits is ignored.
- R3: A window status access (address 2'b10) reads or writes the status register of the record named by the current index, and leaves all other records unchanged.
- R4: When the index is greater than or equal to NUM_RECORDS, window reads return zero and window writes change no record.
- R5: A new index takes effect for the window access in the very next request cycle.
- R6: The ID register (address 2'b00) reads NUM_RECORDS in bits [15:0] and zero above them. Writes to it are ignored.
- R7: Every request with acc_valid high produces exactly one response with rsp_valid high on the next cycle. Write responses return zero data.
- R8: An access to address 2'b11 sets rsp_undef, returns zero data and changes no state.
- R9: With NUM_RECORDS equal to 0, select register accesses set rsp_undef when ZERO_REC_UNDEF is 1. When ZERO_REC_UNDEF is 0, they read zero and ignore writes.
- R10: With FEATURE_EN equal to 0, every access sets rsp_undef and returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 00 ID, 01 select, 10 window status, 11 unmapped |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero for writes and undefined accesses |
| rsp_undef | output | 1 | Undefined-access indication |

## Verification
The bound checker checks, on every cycle, the following properties:

- the one-cycle request-to-response timing and the zero data on write responses;
- the reserved upper select bits;
- the ID value;
- the zero data returned for out-of-range window reads;
- the undefined flag on the unmapped address.

Only the bench's scenarios can show the remaining behaviours:

- that a window write lands on the chosen record and on no other;
- that an out-of-range write leaves every record untouched;
- that a back-to-back select-then-access sequence uses the new index.

The zero-record and disabled variants are covered by separate bench instances.

// File: rtl/err_window.sv
module err_window #(
  parameter int NUM_RECORDS    = 8,
  parameter bit FEATURE_EN     = 1'b1,
  parameter bit ZERO_REC_UNDEF = 1'b1,
  parameter int IDX_W          = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_addr,
  input  logic [63:0] acc_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_undef
);
  localparam int DEPTH = (NUM_RECORDS > 0) ? NUM_RECORDS : 1;
  localparam int RW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] A_ID = 2'b00, A_SEL = 2'b01, A_WIN = 2'b10;
  localparam bit SEL_UNDEF = (NUM_RECORDS == 0) && ZERO_REC_UNDEF;
  localparam bit SEL_LIVE  = (NUM_RECORDS != 0);

  logic [IDX_W-1:0] sel_q;
  logic [63:0]      status_q [DEPTH];
  logic             in_range, undef, sel_we, win_we;
  logic [63:0]      rdata_n;
  logic [RW-1:0]    rd_idx;

  assign in_range = ({{(32-IDX_W){1'b0}}, sel_q} < 32'(NUM_RECORDS));
  assign undef    = !FEATURE_EN || (acc_addr == 2'b11) || ((acc_addr == A_SEL) && SEL_UNDEF);
  assign sel_we   = acc_valid && acc_write && !undef && (acc_addr == A_SEL) && SEL_LIVE;
  assign win_we   = acc_valid && acc_write && !undef && (acc_addr == A_WIN) && in_range;
  assign rd_idx   = sel_q[RW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= acc_wdata[IDX_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                     status_q[g] <= '0;
      else if (win_we && (rd_idx == RW'(g)))          status_q[g] <= acc_wdata;
  end

  always_comb begin
    rdata_n = '0;
    if (!acc_write && !undef)
      case (acc_addr)
        A_ID:    rdata_n = {48'b0, 16'(NUM_RECORDS)};
        A_SEL:   rdata_n = SEL_LIVE ? {{(64-IDX_W){1'b0}}, sel_q} : 64'b0;
        A_WIN:   rdata_n = in_range ? status_q[rd_idx] : 64'b0;
        default: rdata_n = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= acc_valid ? rdata_n : 64'b0;
      rsp_undef <= acc_valid && undef;
    end
endmodule

// File: rtl/err_window_chk.sv
module err_window_chk #(
  parameter int NUM_RECORDS = 8,
  parameter bit FEATURE_EN  = 1'b1,
  parameter int IDX_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [1:0]       acc_addr,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic             rsp_undef,
  input logic [IDX_W-1:0] sel_q
);
  logic oor;
  assign oor = ({{(32-IDX_W){1'b0}}, sel_q} >= 32'(NUM_RECORDS));

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> rsp_valid); // R7
  AST_RSP_HAS_REQ:   assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(acc_valid)); // R7
  AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(acc_write)) |-> (rsp_rdata == 64'b0)); // R7
  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(acc_addr) == 2'b01) |-> (rsp_rdata[63:16] == 48'b0)); // R2
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_undef && $past(!acc_write && acc_addr == 2'b00)) |-> (rsp_rdata == 64'(NUM_RECORDS))); // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!acc_write && acc_addr == 2'b10 && oor)) |-> (rsp_rdata == 64'b0)); // R4
  AST_UNMAPPED_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(acc_addr) == 2'b11) |-> (rsp_undef && rsp_rdata == 64'b0)); // R8
  AST_OFF_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !FEATURE_EN) |-> rsp_undef); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && acc_write && acc_addr == 2'b01) |-> $stable(sel_q)); // R5
endmodule

bind err_window err_window_chk #(.NUM_RECORDS(NUM_RECORDS), .FEATURE_EN(FEATURE_EN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .sel_q(sel_q));

// File: tb/err_window_bench.sv
module err_window_bench;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic acc_valid = 0, acc_write = 0;
  logic [1:0] acc_addr = 0;
  logic [63:0] acc_wdata = 0;
  logic rsp_valid, rsp_undef;
  logic [63:0] rsp_rdata;

  logic [3:0]  x_valid = 0;
  logic        x_write = 0;
  logic [1:0]  x_addr = 0;
  logic [63:0] x_wdata = 0;
  logic [2:0]  x_rv, x_ru;
  logic [63:0] x_rd [3];

  int checks = 0, fails = 0;

  err_window #(.NUM_RECORDS(N)) u_err_window (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata,
    .rsp_valid, .rsp_rdata, .rsp_undef);
  err_window #(.NUM_RECORDS(0), .ZERO_REC_UNDEF(1'b1)) u_err_window_z1 (
    .clk, .rst_n, .acc_valid(x_valid[0]), .acc_write(x_write), .acc_addr(x_addr), .acc_wdata(x_wdata),
    .rsp_valid(x_rv[0]), .rsp_rdata(x_rd[0]), .rsp_undef(x_ru[0]));
  err_window #(.NUM_RECORDS(0), .ZERO_REC_UNDEF(1'b0)) u_err_window_z0 (
    .clk, .rst_n, .acc_valid(x_valid[1]), .acc_write(x_write), .acc_addr(x_addr), .acc_wdata(x_wdata),
    .rsp_valid(x_rv[1]), .rsp_rdata(x_rd[1]), .rsp_undef(x_ru[1]));
  err_window #(.NUM_RECORDS(N), .FEATURE_EN(1'b0)) u_err_window_off (
    .clk, .rst_n, .acc_valid(x_valid[2]), .acc_write(x_write), .acc_addr(x_addr), .acc_wdata(x_wdata),
    .rsp_valid(x_rv[2]), .rsp_rdata(x_rd[2]), .rsp_undef(x_ru[2]));

  typedef struct { logic [63:0] data; logic undef; string req; } exp_t;
  exp_t q[$];
  logic [15:0] m_sel = 0;
  logic [63:0] m_stat [N];

  task automatic fail_line(string req, logic [64:0] act, logic [64:0] exp);
    fails++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic drive(logic w, logic [1:0] a, logic [63:0] d, string req);
    exp_t e;
    e.data = 0; e.undef = 0; e.req = req;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d;
    case (a)
      2'b00: if (!w) e.data = 64'(N);
      2'b01: if (w) m_sel = d[15:0]; else e.data = {48'b0, m_sel};
      2'b10: if (m_sel < 16'(N)) begin
               if (w) m_stat[m_sel[2:0]] = d; else e.data = m_stat[m_sel[2:0]];
             end
      default: e.undef = 1;
    endcase
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk); acc_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    exp_t e;
    checks++;
    if (q.size() == 0) fail_line("R7 unexpected response", {rsp_undef, rsp_rdata}, 65'b0);
    else begin
      e = q.pop_front();
      if (rsp_rdata !== e.data || rsp_undef !== e.undef)
        fail_line(e.req, {rsp_undef, rsp_rdata}, {e.undef, e.data});
    end
  end

  task automatic xacc(logic w, logic [1:0] a, logic [63:0] d,
                      logic [2:0] eu, logic [63:0] e0, logic [63:0] e1, logic [63:0] e2, string req);
    logic [63:0] ed [3];
    ed[0] = e0; ed[1] = e1; ed[2] = e2;
    @(negedge clk);
    x_valid = 4'b0111; x_write = w; x_addr = a; x_wdata = d;
    @(negedge clk);
    x_valid = 0;
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (x_rv[i] !== 1'b1 || x_ru[i] !== eu[i] || x_rd[i] !== ed[i])
        fail_line(req, {x_ru[i], x_rd[i]}, {eu[i], ed[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_stat[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    drive(0, 2'b01, 0, "R1 select after reset");
    for (int i = 0; i < N; i++) begin
      drive(1, 2'b01, 64'(i), "R7 write response");
      drive(0, 2'b10, 0, "R1 record after reset");
    end
    // R6 ID
    drive(0, 2'b00, 0, "R6 ID read");
    drive(1, 2'b00, 64'hFFFF, "R6 ID write ignored");
    drive(0, 2'b00, 0, "R6 ID after write");
    // R2 upper bits ignored
    drive(1, 2'b01, 64'hDEAD_BEEF_0000_0004, "R2 select write");
    drive(0, 2'b01, 0, "R2 select upper zero");
    // R3 targeted window writes, R5 back-to-back
    for (int i = 0; i < N; i++) begin
      drive(1, 2'b01, 64'(i), "R5 select write");
      drive(1, 2'b10, 64'hA5A5_0000_0000_0000 | 64'(i * 17), "R3 window write");
    end
    for (int i = N - 1; i >= 0; i--) begin
      drive(1, 2'b01, 64'(i), "R5 select write");
      drive(0, 2'b10, 0, "R3 R5 window read");
    end
    idle();
    // R4 out of range
    drive(1, 2'b01, 64'(N), "R4 select oor");
    drive(0, 2'b10, 0, "R4 oor read zero");
    drive(1, 2'b10, 64'h1234, "R4 oor write");
    drive(1, 2'b01, 64'hFFFF, "R4 select max");
    drive(1, 2'b10, 64'h5678, "R4 oor write");
    drive(0, 2'b10, 0, "R4 oor read zero");
    for (int i = 0; i < N; i++) begin
      drive(1, 2'b01, 64'(i), "R4 reselect");
      drive(0, 2'b10, 0, "R4 records untouched");
    end
    // R8 unmapped
    drive(1, 2'b01, 64'd3, "R8 select");
    drive(1, 2'b11, 64'hFFFF_FFFF, "R8 unmapped write undef");
    drive(0, 2'b11, 0, "R8 unmapped read undef");
    drive(0, 2'b01, 0, "R8 select unchanged");
    drive(0, 2'b10, 0, "R8 record unchanged");
    idle();
    idle();
    checks++;
    if (q.size() != 0) fail_line("R7 missing responses", 65'(q.size()), 65'b0);
    // R9 / R10 variants: index 0 z1, 1 z0, 2 off
    xacc(0, 2'b01, 0, 3'b101, 0, 0, 0, "R9 R10 select read");
    xacc(1, 2'b01, 64'd5, 3'b101, 0, 0, 0, "R9 R10 select write");
    xacc(0, 2'b01, 0, 3'b101, 0, 0, 0, "R9 select write ignored");
    xacc(0, 2'b00, 0, 3'b100, 0, 0, 0, "R9 R10 ID read zero records");
    xacc(1, 2'b10, 64'h77, 3'b100, 0, 0, 0, "R9 R10 window write");
    xacc(0, 2'b10, 0, 3'b100, 0, 0, 0, "R9 R10 window read");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule